// File: doc/BRIEF.md
# Ternary Bitwise Logic Unit

This unit evaluates any three-input Boolean function, bit by bit, over three XLEN-bit operands. The function is given as an 8-bit truth table that travels with the operation as an immediate. The first operand is the old value of the destination register, so the unit computes a new destination value from the old one and two more sources. Every bit position is handled on its own and no bit affects a neighbour.

An operation is offered for one cycle with `in_valid`. The unit registers the result and asserts `out_done` on the next cycle. The result register keeps its value until the next operation. When the record bit is set, the unit also writes a 4-bit condition field. That field is a signed comparison of the result against zero, together with a copy of the summary-overflow flag that comes in with the operation. When the record bit is clear, the condition field is left as it was. Register-file access and instruction decode are outside this unit.

Top module: `ternlogic_unit`

## Requirements
- R1: For each bit position j, let idx = 4*in_old_dst[j] + 2*in_src_a[j] + in_src_b[j]. Then out_result[j] equals in_tbl[idx], where in_tbl[0] is the least significant bit of the immediate.
- R2: `out_done` is high for exactly the one cycle after each cycle in which `in_valid` is high, and is low in every other cycle. The new `out_result` appears in that same cycle.
- R3: While `in_valid` is low, `out_result` keeps its last value.
- R4: When an operation is accepted with `in_record` = 1, `out_cond_we` is high together with `out_done` and `out_cond` is loaded. In every other case `out_cond_we` is low and `out_cond` does not change.
- R5: When `out_cond` is loaded: bit 3 (LT) = result bit XLEN-1; bit 2 (GT) = result nonzero and bit XLEN-1 clear; bit 1 (EQ) = result all zero; bit 0 = `in_so` of that operation.
- R6: A table of 0xFF gives an all-ones result and 0x00 gives an all-zeros result, whatever the operands.
- R7: Operand roles are fixed. Table 0xF0 returns `in_old_dst`, 0xCC returns `in_src_a`, and 0xAA returns `in_src_b`.
- R8: After reset, `out_done`, `out_cond_we`, `out_result` and `out_cond` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation strobe |
| in_old_dst | input | XLEN | Previous destination value (index MSB) |
| in_src_a | input | XLEN | Second operand (index middle bit) |
| in_src_b | input | XLEN | Third operand (index LSB) |
| in_tbl | input | 8 | Truth-table immediate |
| in_record | input | 1 | Update the condition field |
| in_so | input | 1 | Summary-overflow flag to copy |
| out_done | output | 1 | Result valid, one cycle after strobe |
| out_result | output | XLEN | Registered result |
| out_cond_we | output | 1 | Condition field written this cycle |
| out_cond | output | 4 | Condition field {LT,GT,EQ,SO} |

## Verification
The bench checks the three single-operand tables. A design that swapped the index bits would return the wrong operand for 0xF0 or 0xAA. A design that read the immediate from the opposite end would give the complement pattern, which random tables and operands also expose. For the condition field, the bench uses a result with only the sign bit set, a zero result and a small positive result. A signed/unsigned mix-up would report GT for a negative value. It also interleaves record-clear operations with record-set ones, because a design that wrote the field on every operation would lose the held flags. Back-to-back strobes and idle gaps catch a done pulse that stretches or a result that drifts.

// File: rtl/ternlogic_unit.sv
module ternlogic_unit #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [XLEN-1:0] in_old_dst,
  input  logic [XLEN-1:0] in_src_a,
  input  logic [XLEN-1:0] in_src_b,
  input  logic [7:0]      in_tbl,
  input  logic            in_record,
  input  logic            in_so,
  output logic            out_done,
  output logic [XLEN-1:0] out_result,
  output logic            out_cond_we,
  output logic [3:0]      out_cond
);

  logic [XLEN-1:0] res_next;

  for (genvar j = 0; j < XLEN; j++) begin : g_bit
    assign res_next[j] = in_tbl[{in_old_dst[j], in_src_a[j], in_src_b[j]}];
  end

  wire is_zero = (res_next == '0);
  wire is_neg  = res_next[XLEN-1];
  wire [3:0] cond_next = {is_neg, !is_neg && !is_zero, is_zero, in_so};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_done    <= 1'b0;
      out_cond_we <= 1'b0;
      out_result  <= '0;
      out_cond    <= '0;
    end else begin
      out_done    <= in_valid;
      out_cond_we <= in_valid && in_record;
      if (in_valid) out_result <= res_next;
      if (in_valid && in_record) out_cond <= cond_next;
    end
  end

  a_r2_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_done);
  a_r2_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_done);
  a_r3_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_result));
  a_r4_cond_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_record) |=> ($stable(out_cond) && !out_cond_we));
  a_r4_we_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    out_cond_we |-> out_done);
  a_r5_eq_flag: assert property (@(posedge clk) disable iff (!rst_n)
    out_cond_we |-> (out_cond[1] == (out_result == '0)));
  a_r5_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    out_cond_we |-> $onehot(out_cond[3:1]));
  a_r6_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_tbl == 8'hFF) |=> (out_result == '1));
  a_r7_copy_a: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_tbl == 8'hCC) |=> (out_result == $past(in_src_a)));

endmodule

// File: tb/tb_ternlogic_unit.sv
module tb_ternlogic_unit;
  localparam int XLEN = 64;
  localparam int CLK_PERIOD = 10;

  logic            clk = 0;
  logic            rst_n = 0;
  logic            in_valid = 0;
  logic [XLEN-1:0] in_old_dst = '0, in_src_a = '0, in_src_b = '0;
  logic [7:0]      in_tbl = '0;
  logic            in_record = 0, in_so = 0;
  logic            out_done, out_cond_we;
  logic [XLEN-1:0] out_result;
  logic [3:0]      out_cond;

  ternlogic_unit #(.XLEN(XLEN)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [XLEN-1:0] res;
    logic [3:0]      cond;
    logic            we;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_cmp = 0, n_bad = 0;
  logic [3:0] cond_model = '0;

  task automatic chk(string tag, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(string tag, logic [XLEN-1:0] o, logic [XLEN-1:0] a,
                      logic [XLEN-1:0] b, logic [7:0] t, logic rec, logic so);
    exp_t e;
    @(negedge clk);
    in_valid = 1; in_old_dst = o; in_src_a = a; in_src_b = b;
    in_tbl = t; in_record = rec; in_so = so;
    for (int j = 0; j < XLEN; j++) e.res[j] = t[4*o[j] + 2*a[j] + b[j]];
    if (rec) begin
      cond_model[3] = e.res[XLEN-1];
      cond_model[2] = !e.res[XLEN-1] && (e.res != '0);
      cond_model[1] = (e.res == '0);
      cond_model[0] = so;
    end
    e.cond = cond_model;
    e.we = rec;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 0;
      in_old_dst = {$urandom, $urandom};
      in_tbl = 8'($urandom);
      in_record = 1;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_done) begin
        if (exp_q.size() == 0) begin
          chk("R2 spurious done", 1, 0);
        end else begin
          exp_t e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk({t, " result"}, out_result, e.res);
          chk({t, " cond R5"}, XLEN'(out_cond), XLEN'(e.cond));
          chk({t, " cond_we R4"}, XLEN'(out_cond_we), XLEN'(e.we));
        end
      end else begin
        if (out_cond_we) chk("R4 we without done", 1, 0);
      end
    end
  end

  initial begin
    #(CLK_PERIOD*100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  logic [XLEN-1:0] held;
  logic [XLEN-1:0] ro, ra, rb;

  initial begin
    #(CLK_PERIOD*2 + 1);
    chk("R8 reset done", XLEN'(out_done), 0);
    chk("R8 reset result", out_result, 0);
    chk("R8 reset cond", XLEN'({out_cond_we, out_cond}), 0);
    @(negedge clk); rst_n = 1;

    ro = 64'hF0F0_1234_DEAD_BEEF; ra = 64'h0F0F_5678_CAFE_F00D; rb = 64'h3333_9ABC_0123_4567;
    send("R7 old", ro, ra, rb, 8'hF0, 0, 0);
    send("R7 a",   ro, ra, rb, 8'hCC, 0, 0);
    send("R7 b",   ro, ra, rb, 8'hAA, 1, 1);
    idle(2);
    send("R6 ones",  ro, ra, rb, 8'hFF, 1, 0);
    send("R6 zeros", ro, ra, rb, 8'h00, 1, 1);
    idle(1);
    send("R5 neg",  64'h8000_0000_0000_0000, '0, '0, 8'hF0, 1, 0);
    send("R5 pos",  '0, 64'h1, '0, 8'hCC, 1, 1);
    send("R4 hold", '0, '0, '0, 8'h00, 0, 0);
    send("R1 xor3", ro, ra, rb, 8'h96, 0, 1);
    send("R1 maj",  ro, ra, rb, 8'hE8, 1, 0);
    idle(2);
    held = out_result;
    idle(3);
    chk("R3 hold", out_result, held);
    chk("R2 idle", XLEN'(out_done), 0);
    for (int n = 0; n < 40; n++) begin
      send("R1 rand", {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
           8'($urandom), 1'($urandom), 1'($urandom));
      if (n % 5 == 0) idle(1);
    end
    idle(3);
    chk("R2 queue drained", XLEN'(exp_q.size()), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule